// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Controller

This block sequences one DMA channel that carries bytes from an endpoint source into system memory through a small staging FIFO. Software, or a fetched descriptor, writes a 32-bit control word. Its two low bits form the command pair {link, enable}. The command selects one of four behaviours: halt now, run to the end of the buffer and halt, skip the current descriptor and fetch the next one, or run to the end of the buffer and then fetch the next descriptor automatically. A 16-bit byte countdown is loaded from the upper half of the word. A length of zero stands for the 32768-byte maximum.

A buffer ends when the countdown reaches zero, or when a short packet arrives while short-packet termination is enabled. Hardware then clears the enable bit. The staging FIFO drains into memory, and only after the FIFO is empty does the channel-enabled status fall. The same drain happens when software disables the channel in the middle of a transfer. Three sticky flags record three events: end of buffer, end of transfer and descriptor loaded. Each flag reaches the interrupt output only through its own enable bit, and each is cleared by a write-one strobe. Descriptor words arrive over a request/acknowledge port.

Top module: `dma_chan_ctl`

Control word layout:
- bit 0: enable
- bit 1: link
- bit 2: short-packet termination enable
- bit 3: packet-validate enable
- bit 4: end-of-buffer interrupt enable
- bit 5: end-of-transfer interrupt enable
- bit 6: descriptor-loaded interrupt enable
- bit 7: bus-hold hint, stored only
- bits 31:16: length

Flag vector layout:
- bit 0: end of buffer
- bit 1: end of transfer
- bit 2: descriptor loaded

## Requirements
- R1: After reset the following all read zero: `ch_en`, `ch_act`, `dsc_req`, `flags`, `irq`, `byte_cnt` and `ctl_rd`.
- R2: A control write whose bits 1:0 are not 00 stores bits 7:0 and loads `byte_cnt` from bits 31:16, where a value of 0 loads 16'h8000. Writing enable=1 sets `ch_en` on the next clock.
- R3: A control write with bits 1:0 = 00 changes only the command bits. `byte_cnt` and `ctl_rd[7:2]` keep their values.
- R4: While running, every accepted source byte (`src_pop`) lowers `byte_cnt` by one. The bytes leave on `mem_data` in the order they were accepted. Under command 01, the byte that brings the count to zero sets flag bit 0 and clears `ctl_rd[0]`, and no descriptor fetch follows.
- R5: Under command 11, once the buffer ends and `ch_en` falls, `dsc_req` rises with no `xfer_req` needed.
- R6: Under command 10, no byte is moved. `dsc_req` rises one clock after `xfer_req` is seen, and only while `ch_en` is low.
- R7: On a clock where `dsc_req` and `dsc_ack` are both high, `dsc_word` is loaded in the same way as a non-stop control write, and `dsc_req` falls. Flag bit 2 rises one clock later.
- R8: Once enable is cleared mid-transfer, `src_pop` stays low, the FIFO keeps draining to memory, and `ch_en` falls only after `ch_act` (FIFO non-empty) has gone low.
- R9: A `short_pkt` pulse while running with control bit 2 set sets flag bit 1 and ends the buffer. With bit 2 clear, the pulse has no effect.
- R10: `pkt_valid` pulses once for an end of buffer when control bit 3 is set, and never pulses when bit 3 is clear.
- R11: `irq` is high exactly when a set flag has its enable set. The pairings are flag 0 with control bit 4, flag 1 with bit 5, and flag 2 with bit 6.
- R12: A one in `sts_clr[i]` clears flag bit i. If the same flag is set by an event in that clock, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word |
| sts_clr | input | 3 | Write-one-to-clear strobes for the flags |
| xfer_req | input | 1 | Source has a byte ready / transfer request |
| src_data | input | 8 | Source byte |
| src_pop | output | 1 | Source byte accepted this clock |
| short_pkt | input | 1 | Short packet ended the transfer |
| mem_rdy | input | 1 | Memory side can take a byte |
| mem_push | output | 1 | Byte presented on mem_data is taken this clock |
| mem_data | output | 8 | Byte toward memory |
| dsc_req | output | 1 | Descriptor fetch request |
| dsc_ack | input | 1 | Descriptor word valid |
| dsc_word | input | 32 | Fetched control word |
| ch_en | output | 1 | Channel-enabled status |
| ch_act | output | 1 | Channel active (staging FIFO holds data) |
| byte_cnt | output | 16 | Remaining byte countdown |
| ctl_rd | output | 8 | Stored control bits |
| flags | output | 3 | Sticky status flags |
| irq | output | 1 | Interrupt |
| pkt_valid | output | 1 | Packet-validate pulse at end of buffer |

## Verification
The byte path is tried in three ways. The first is a full 32768-byte buffer from a zero length, which separates the zero-means-maximum rule from an ordinary count. The second is a short counted buffer with validation disabled, which separates the flag from the validate pulse. The third holds back the memory side so the FIFO fills and is then drained after a stop, which shows that `ch_en` falls only after the last byte leaves. Short packets are sent once with termination disabled and once with it enabled. The three fetch paths are each exercised: skip-on-request, automatic link after drain, and the load timing of the word and its flag.

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl #(
  parameter int DW         = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int LEN_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [31:0]      ctl_wdata,
  input  logic [2:0]       sts_clr,
  input  logic             xfer_req,
  input  logic [DW-1:0]    src_data,
  output logic             src_pop,
  input  logic             short_pkt,
  input  logic             mem_rdy,
  output logic             mem_push,
  output logic [DW-1:0]    mem_data,
  output logic             dsc_req,
  input  logic             dsc_ack,
  input  logic [31:0]      dsc_word,
  output logic             ch_en,
  output logic             ch_act,
  output logic [LEN_W-1:0] byte_cnt,
  output logic [7:0]       ctl_rd,
  output logic [2:0]       flags,
  output logic             irq,
  output logic             pkt_valid
);
  localparam int PW = $clog2(FIFO_DEPTH);
  localparam logic [PW:0] FULL = (PW+1)'(FIFO_DEPTH);
  localparam logic [LEN_W-1:0] MAXLEN = LEN_W'(1) << (LEN_W-1);

  logic [7:0]       ctl_q;
  logic [LEN_W-1:0] cnt_q;
  logic             st_en_q, lnk_q, dld_pend_q, pv_q;
  logic [2:0]       flg_q;
  logic [DW-1:0]    fifo [FIFO_DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [PW:0]      fcnt;

  function automatic logic [LEN_W-1:0] len_of(input logic [31:0] w);
    return (w[16 +: LEN_W] == '0) ? MAXLEN : w[16 +: LEN_W];
  endfunction

  wire run     = st_en_q & ctl_q[0];
  assign src_pop  = run & xfer_req & (fcnt != FULL) & (cnt_q != '0);
  assign mem_push = mem_rdy & (fcnt != '0);
  assign mem_data = fifo[rp];
  wire last    = src_pop & (cnt_q == LEN_W'(1));
  wire eot     = short_pkt & run & ctl_q[2];
  wire hw_end  = last | eot;
  wire load    = dsc_req & dsc_ack;
  wire wr_full = ctl_we & (ctl_wdata[1:0] != 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0; cnt_q <= '0; lnk_q <= 1'b0;
    end else if (ctl_we) begin
      ctl_q[1:0] <= ctl_wdata[1:0];
      lnk_q <= 1'b0;
      if (wr_full) begin
        ctl_q[7:2] <= ctl_wdata[7:2];
        cnt_q <= len_of(ctl_wdata);
      end
    end else if (load) begin
      ctl_q <= dsc_word[7:0];
      cnt_q <= len_of(dsc_word);
      lnk_q <= 1'b0;
    end else begin
      if (src_pop) cnt_q <= cnt_q - LEN_W'(1);
      if (hw_end) begin
        ctl_q[0] <= 1'b0;
        lnk_q <= ctl_q[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_en_q <= 1'b0; dsc_req <= 1'b0; dld_pend_q <= 1'b0;
      pv_q <= 1'b0; flg_q <= '0;
    end else begin
      if ((ctl_we & ctl_wdata[0]) | (load & dsc_word[0])) st_en_q <= 1'b1;
      else if (!ctl_q[0] && fcnt == '0)                   st_en_q <= 1'b0;
      if (load || ctl_we) dsc_req <= 1'b0;
      else if (ctl_q[1] && !ctl_q[0] && !st_en_q && (xfer_req || lnk_q))
        dsc_req <= 1'b1;
      dld_pend_q <= load;
      pv_q <= last & ctl_q[3];
      flg_q <= (flg_q & ~sts_clr) | {dld_pend_q, eot, last};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fcnt <= '0;
    end else begin
      if (src_pop)  wp <= wp + 1'b1;
      if (mem_push) rp <= rp + 1'b1;
      fcnt <= fcnt + (PW+1)'(src_pop) - (PW+1)'(mem_push);
    end
  end

  always_ff @(posedge clk) if (src_pop) fifo[wp] <= src_data;

  assign ch_en     = st_en_q;
  assign ch_act    = (fcnt != '0);
  assign byte_cnt  = cnt_q;
  assign ctl_rd    = ctl_q;
  assign flags     = flg_q;
  assign pkt_valid = pv_q;
  assign irq       = |(flg_q & ctl_q[6:4]);
endmodule

// File: rtl/dma_chan_ctl_chk.sv
module dma_chan_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_we,
  input logic        src_pop,
  input logic        dsc_req,
  input logic        dsc_ack,
  input logic        ch_en,
  input logic        ch_act,
  input logic [15:0] byte_cnt,
  input logic [2:0]  flags,
  input logic        irq,
  input logic        pkt_valid
);
  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pop && !ctl_we && !(dsc_req && dsc_ack)) |=> byte_cnt == $past(byte_cnt) - 16'd1);

  p_fetch_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_req |-> (!ch_en && !src_pop));

  p_dld_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_req && dsc_ack) |=> ##1 flags[2]);

  p_stop_after_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ch_en) |-> !ch_act);

  p_validate_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> flags[0]);

  p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != 3'b000));
endmodule

bind dma_chan_ctl dma_chan_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .src_pop(src_pop),
  .dsc_req(dsc_req), .dsc_ack(dsc_ack), .ch_en(ch_en), .ch_act(ch_act),
  .byte_cnt(byte_cnt), .flags(flags), .irq(irq), .pkt_valid(pkt_valid)
);

// File: tb/tb_dma_chan_ctl.sv
module tb_dma_chan_ctl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [2:0]  sts_clr = '0;
  logic        xfer_req = 1'b0;
  logic [7:0]  src_data;
  logic        src_pop, short_pkt = 1'b0, mem_rdy = 1'b1, mem_push;
  logic [7:0]  mem_data;
  logic        dsc_req, dsc_ack = 1'b0;
  logic [31:0] dsc_word = '0;
  logic        ch_en, ch_act, irq, pkt_valid;
  logic [15:0] byte_cnt;
  logic [7:0]  ctl_rd;
  logic [2:0]  flags;

  int n_chk = 0, n_fail = 0, idx = 0, pop_n = 0, push_n = 0, pv_n = 0;
  bit done = 0;
  logic [7:0] exp_q [$];

  dma_chan_ctl dut (.*);

  always #4 clk = ~clk;

  function automatic logic [7:0] pat(int i);
    return 8'(i * 13 + 5);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [31:0] w);
    tick(); ctl_we = 1'b1; ctl_wdata = w;
    tick(); ctl_we = 1'b0;
  endtask

  task automatic clr_counts();
    pop_n = 0; push_n = 0; pv_n = 0;
  endtask

  task automatic clr_flags();
    sts_clr = 3'b111; tick(); sts_clr = 3'b000;
  endtask

  task automatic wait_off(int maxc, string req);
    int k = 0;
    while (ch_en && k < maxc) begin tick(); k++; end
    chk(!ch_en, req, ch_en, 0);
  endtask

  // source driver pushes each handed-over byte; memory monitor compares
  initial begin
    src_data = pat(0);
    forever begin
      bit p, m, v;
      logic [7:0] md;
      @(negedge clk);
      p = src_pop; m = mem_push; md = mem_data; v = pkt_valid;
      if (m) begin
        push_n++;
        if (exp_q.size() == 0) chk(0, "R4 order", md, -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(md == e, "R4 order", md, e);
        end
      end
      if (p) begin exp_q.push_back(src_data); pop_n++; end
      if (v) pv_n++;
      @(posedge clk); #1;
      if (p) begin idx++; src_data = pat(idx); end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1
    chk(!ch_en && !ch_act && !dsc_req, "R1 status", {ch_en, ch_act, dsc_req}, 0);
    chk(flags == 0 && !irq, "R1 flags", {flags, irq}, 0);
    chk(byte_cnt == 0 && ctl_rd == 0, "R1 regs", {byte_cnt, ctl_rd}, 0);

    // R2: zero length means maximum
    wr(32'h0000_0019);
    chk(byte_cnt == 16'h8000, "R2 zero length", byte_cnt, 16'h8000);
    chk(ch_en, "R2 enable", ch_en, 1);

    // R3: stop-now keeps upper fields
    wr(32'hABCD_00E4);
    chk(byte_cnt == 16'h8000, "R3 length kept", byte_cnt, 16'h8000);
    chk(ctl_rd == 8'h18, "R3 bits kept", ctl_rd, 8'h18);
    tick();
    chk(!ch_en, "R3 stopped", ch_en, 0);

    // R4, R2, R10, R11: full 32768-byte buffer
    clr_counts();
    xfer_req = 1'b1;
    wr(32'h0000_0019);
    wait_off(40000, "R4 full buffer end");
    xfer_req = 1'b0;
    tick();
    chk(pop_n == 32768 && push_n == 32768, "R2 max transfer", pop_n, 32768);
    chk(exp_q.size() == 0, "R4 nothing lost", exp_q.size(), 0);
    chk(flags[0] && ctl_rd[0] == 1'b0, "R4 eob and enable cleared", {flags[0], ctl_rd[0]}, 2'b10);
    chk(pv_n == 1, "R10 validate pulse", pv_n, 1);
    chk(irq, "R11 eob irq", irq, 1);
    repeat (3) tick();
    chk(!dsc_req, "R4 no fetch", dsc_req, 0);

    // R12
    clr_flags();
    chk(flags == 0 && !irq, "R12 clear", {flags, irq}, 0);

    // R4 short buffer, validate disabled, irq disabled
    clr_counts();
    xfer_req = 1'b1;
    wr(32'h0005_0001);
    wait_off(30, "R4 short buffer end");
    xfer_req = 1'b0;
    tick();
    chk(pop_n == 5 && push_n == 5, "R4 count 5", pop_n, 5);
    chk(pv_n == 0, "R10 validate disabled", pv_n, 0);
    chk(flags[0] && !irq, "R11 masked", {flags[0], irq}, 2'b10);
    clr_flags();

    // R8: drain after mid-transfer disable
    clr_counts();
    mem_rdy = 1'b0; xfer_req = 1'b1;
    wr(32'h0014_0001);
    repeat (8) tick();
    chk(pop_n == 4 && ch_act, "R8 fifo full", pop_n, 4);
    chk(byte_cnt == 16, "R4 countdown", byte_cnt, 16);
    wr(32'h0000_0000);
    repeat (3) tick();
    chk(ch_en && pop_n == 4 && !src_pop, "R8 held while full", {ch_en, src_pop}, 2'b10);
    mem_rdy = 1'b1;
    wait_off(20, "R8 drained stop");
    chk(push_n == 4 && !ch_act, "R8 all drained", push_n, 4);
    chk(flags == 0 && byte_cnt == 16, "R8 no eob", {flags, byte_cnt}, 16);
    xfer_req = 1'b0;

    // R9: short packet ignored, then honoured
    clr_counts();
    xfer_req = 1'b1;
    wr(32'h0064_0021);
    repeat (3) tick();
    short_pkt = 1'b1; tick(); short_pkt = 1'b0; tick();
    chk(flags[1] == 0 && ch_en && ctl_rd[0], "R9 ignored", {flags[1], ch_en, ctl_rd[0]}, 3'b011);
    wr(32'h0000_0000);
    wait_off(20, "R8 stop");
    clr_counts();
    wr(32'h0064_0025);
    repeat (3) tick();
    short_pkt = 1'b1; tick(); short_pkt = 1'b0;
    wait_off(20, "R9 closed");
    xfer_req = 1'b0;
    tick();
    chk(flags[1] && irq && !ctl_rd[0], "R9 eot flag", {flags[1], irq, ctl_rd[0]}, 3'b110);
    chk(pop_n < 100 && push_n == pop_n, "R9 early end", pop_n, push_n);
    clr_flags();

    // R6, R7: load-next-now
    clr_counts();
    wr(32'h0000_0002);
    repeat (5) tick();
    chk(!dsc_req && !ch_en && pop_n == 0, "R6 waits for request", {dsc_req, ch_en}, 0);
    xfer_req = 1'b1;
    tick();
    chk(dsc_req && !src_pop, "R6 fetch on request", {dsc_req, src_pop}, 2'b10);
    dsc_word = 32'h0003_0041; dsc_ack = 1'b1;
    tick();
    dsc_ack = 1'b0;
    chk(byte_cnt == 3 && !dsc_req, "R7 word loaded", byte_cnt, 3);
    chk(flags[2] == 0, "R7 flag not yet", flags[2], 0);
    tick();
    chk(flags[2] && irq, "R7 flag next cycle", {flags[2], irq}, 2'b11);
    wait_off(20, "R7 loaded run");
    xfer_req = 1'b0;
    tick();
    chk(pop_n == 3 && pv_n == 0, "R7 moved 3", pop_n, 3);
    clr_flags();

    // R5: run-and-link
    clr_counts();
    xfer_req = 1'b1;
    wr(32'h0002_0003);
    wait_off(20, "R5 buffer end");
    xfer_req = 1'b0;
    begin
      int k = 0;
      while (!dsc_req && k < 4) begin tick(); k++; end
    end
    chk(dsc_req && !xfer_req, "R5 auto fetch", dsc_req, 1);
    chk(pop_n == 2, "R5 bytes", pop_n, 2);
    dsc_word = 32'h0000_0000; dsc_ack = 1'b1;
    tick();
    dsc_ack = 1'b0;
    tick();
    chk(!dsc_req && !ch_en && flags[2], "R5 link stop loaded", {dsc_req, ch_en, flags[2]}, 3'b001);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule